// File: doc/BRIEF.md
# Selectable-Timebase Timestamp Counter

This block keeps a free-running timestamp that software reads over a 32-bit register interface. One register picks the timebase and carries a hold control; a second register returns the running count. Three timebases exist, each derived from a 50 MHz system clock. The finest one counts nanoseconds: it adds 20 on every 20 ns system clock. The second adds one per microsecond (every 50 clocks) and the third adds one per millisecond (every 50000 clocks).

To zero the count, software writes the configuration register with the hold bit set and the wanted source, then writes the same source with the hold bit cleared. While the hold bit is set, the count stays at zero and the prescaler stays cleared. Counting resumes on the clock after the write that clears the bit. A source code above 2 parks the counter at its present value. A change of source restarts the prescaler phase and keeps the count as it is. The count rolls over silently at the top of its range.

Top module: `ts_counter_top`

## Requirements
- R1: While reset is asserted, the configuration register (address 0x600) and the count register (address 0x602) both read 0.
- R2: A write to 0x600 stores wr_data[8:0]: bits 7:0 are the source code and bit 8 is the hold bit. A read of 0x600 returns those 9 bits with bits 31:9 always zero. Bits 31:9 of the written data are discarded.
- R3: While the stored hold bit is 1, the count register reads 0 from the clock after the write that set it.
- R4: With source 0 and hold clear, the count after the k-th rising edge following the releasing write is 20*k (mod 2^CNT_W).
- R5: With source 1 and hold clear, the count after the k-th edge following the release is floor(k/50).
- R6: With source 2 and hold clear, the count after the k-th edge following the release is floor(k/50000).
- R7: With a source code greater than 2, the count does not change.
- R8: A write that changes the source code clears the prescaler phase and keeps the count value, so the first increment under the new source comes a full period after that write.
- R9: The count wraps from its maximum value to the value modulo 2^CNT_W, with no flag and no other effect. In every cycle with hold clear, the count either stays the same or advances by exactly the active step.
- R10: Writes to any address other than 0x600, including the count address 0x602, change neither register. Reads of addresses other than 0x600 and 0x602 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Combinational read data for rd_addr |

## Verification
The assertions check on every cycle that a held counter sits at zero, and that the nanosecond source adds exactly its step. They also check that an invalid source freezes the count, that any running count either stays or advances by one step with wrap, that a source change clears the prescaler, and that the upper configuration read bits stay zero. Only the bench's scenarios can show the exact cycle of the microsecond and millisecond increments after a release or a source change. The same holds for the roll-over at a narrow counter width and for the silence of writes to the count address and to unmapped addresses.

// File: rtl/ts_pkg.sv
package ts_pkg;

  localparam int unsigned SRC_W    = 8;
  localparam int unsigned HOLD_BIT = 8;

  localparam logic [SRC_W-1:0] SRC_NSEC = 8'd0;
  localparam logic [SRC_W-1:0] SRC_USEC = 8'd1;
  localparam logic [SRC_W-1:0] SRC_MSEC = 8'd2;
  localparam logic [SRC_W-1:0] SRC_TOP  = SRC_MSEC;

  typedef struct packed {
    logic             hold;
    logic [SRC_W-1:0] src;
  } ts_cfg_t;

  // true when the source code selects a real timebase
  function automatic logic src_runs(logic [SRC_W-1:0] s);
    return s <= SRC_TOP;
  endfunction

  // system clocks per increment for a source
  function automatic int unsigned div_for(logic [SRC_W-1:0] s,
                                          int unsigned us_div,
                                          int unsigned ms_div);
    case (s)
      SRC_USEC: return us_div;
      SRC_MSEC: return ms_div;
      default:  return 1;
    endcase
  endfunction

  // amount added per increment for a source
  function automatic int unsigned step_for(logic [SRC_W-1:0] s,
                                           int unsigned ns_step);
    return (s == SRC_NSEC) ? ns_step : 1;
  endfunction

endpackage

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
  import ts_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CFG_ADDR = 'h600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output ts_cfg_t           cfg,
  output logic              src_change
);

  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

  logic    cfg_hit;
  ts_cfg_t cfg_q;
  ts_cfg_t cfg_next;
  logic    unused_wr_hi;

  assign cfg_hit       = wr_en && (wr_addr == CFG_A);
  assign cfg_next.hold = wr_data[HOLD_BIT];
  assign cfg_next.src  = wr_data[SRC_W-1:0];
  assign unused_wr_hi  = ^wr_data[31:HOLD_BIT+1];

  // a write that lands a different source restarts the prescaler phase
  assign src_change = cfg_hit && (cfg_next.src != cfg_q.src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (cfg_hit) cfg_q <= cfg_next;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/ts_prescaler.sv
module ts_prescaler
  import ts_pkg::*;
#(
  parameter int unsigned US_DIV = 50,
  parameter int unsigned MS_DIV = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hold,
  input  logic [SRC_W-1:0] src,
  output logic             tick,
  output logic [$clog2(MS_DIV)-1:0] phase
);

  localparam int unsigned DIV_W = $clog2(MS_DIV);

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last_phase;
  logic             running;

  assign running    = !hold && src_runs(src);
  assign last_phase = DIV_W'(div_for(src, US_DIV, MS_DIV) - 1);
  assign tick       = running && (phase_q == last_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (clear || hold)    phase_q <= '0;
    else if (running) begin
      if (phase_q == last_phase) phase_q <= '0;
      else                       phase_q <= phase_q + 1'b1;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/ts_accum.sv
module ts_accum #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] step,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (hold) count_q <= '0;
    else if (tick) count_q <= count_q + step;
  end

  assign count = count_q;

endmodule

// File: rtl/ts_counter_top.sv
module ts_counter_top
  import ts_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CFG_ADDR = 'h600,
  parameter int unsigned CNT_ADDR = 'h602,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NS_STEP  = 20,
  parameter int unsigned US_DIV   = 50,
  parameter int unsigned MS_DIV   = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);

  localparam int unsigned DIV_W = $clog2(MS_DIV);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_ADDR);

  // named internal events, visible to the bound checker
  ts_cfg_t          cfg;
  logic             src_change;
  logic             presc_clr;
  logic             tick;
  logic [DIV_W-1:0] phase;
  logic [CNT_W-1:0] step_w;
  logic [CNT_W-1:0] count;
  logic [31:0]      count_ext;
  logic [31:0]      cfg_ext;

  ts_cfg_regs #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .src_change(src_change)
  );

  assign presc_clr = src_change;

  ts_prescaler #(.US_DIV(US_DIV), .MS_DIV(MS_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(presc_clr), .hold(cfg.hold),
    .src(cfg.src), .tick(tick), .phase(phase)
  );

  assign step_w = CNT_W'(step_for(cfg.src, NS_STEP));

  ts_accum #(.CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .hold(cfg.hold), .tick(tick),
    .step(step_w), .count(count)
  );

  always_comb begin
    count_ext              = '0;
    count_ext[CNT_W-1:0]   = count;
    cfg_ext                = '0;
    cfg_ext[HOLD_BIT]      = cfg.hold;
    cfg_ext[SRC_W-1:0]     = cfg.src;
  end

  always_comb begin
    if (rd_addr == CFG_A)      rd_data = cfg_ext;
    else if (rd_addr == CNT_A) rd_data = count_ext;
    else                       rd_data = '0;
  end

endmodule

// File: rtl/ts_counter_chk.sv
module ts_counter_chk
  import ts_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CFG_ADDR = 'h600,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NS_STEP  = 20,
  parameter int unsigned DIV_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic [SRC_W-1:0]  src,
  input logic              presc_clr,
  input logic [DIV_W-1:0]  phase,
  input logic [CNT_W-1:0]  step_w,
  input logic [CNT_W-1:0]  count,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data
);

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));

  assert_ns_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && src == SRC_NSEC) |=> (count == $past(count) + CNT_W'(NS_STEP)));

  assert_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !src_runs(src)) |=> $stable(count));

  assert_phase_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> (phase == '0));

  assert_step_or_stay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (count == $past(count)) || (count == $past(count) + $past(step_w)));

  assert_cfg_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(CFG_ADDR)) |-> (rd_data[31:HOLD_BIT+1] == '0));

endmodule

bind ts_counter_top ts_counter_chk #(
  .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .CNT_W(CNT_W),
  .NS_STEP(NS_STEP), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(cfg.hold), .src(cfg.src),
  .presc_clr(presc_clr), .phase(phase), .step_w(step_w), .count(count),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_ts_counter_top.sv
module test_ts_counter_top;

  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] A_CFG = 12'h600;
  localparam logic [AW-1:0] A_CNT = 12'h602;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [31:0]   rd_data_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ts_counter_top i_ts_counter_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // narrow copy: 12-bit count so roll-over is reachable quickly
  ts_counter_top #(.CNT_W(12)) i_ts_counter_top_narrow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_n)
  );

  typedef struct {
    bit          chk_m;
    logic [31:0] exp_m;
    bit          chk_n;
    logic [31:0] exp_n;
    string       tag;
  } sb_item_t;

  sb_item_t sb[$];

  // monitor: compares one pushed item at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        sb_item_t it;
        it = sb.pop_front();
        if (it.chk_m) begin
          n_cmp++;
          if (rd_data !== it.exp_m) begin
            n_bad++;
            $display("FAIL %s wide: actual %h expected %h", it.tag, rd_data, it.exp_m);
          end
        end
        if (it.chk_n) begin
          n_cmp++;
          if (rd_data_n !== it.exp_n) begin
            n_bad++;
            $display("FAIL %s narrow: actual %h expected %h", it.tag, rd_data_n, it.exp_n);
          end
        end
      end
    end
  end

  task automatic probe(input logic [AW-1:0] a, input bit cm, input logic [31:0] em,
                       input bit cn, input logic [31:0] en, input string tag);
    sb_item_t it;
    rd_addr = a;
    it.chk_m = cm; it.exp_m = em; it.chk_n = cn; it.exp_n = en; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic advance(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected counts from the requirements
  function automatic logic [31:0] ns_exp(input int k, input int w);
    longint v;
    v = (longint'(k) * 20) % (longint'(1) << w);
    return 32'(v);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: state during reset
    advance(2);
    probe(A_CFG, 1, 32'h0, 1, 32'h0, "R1 cfg in reset");
    probe(A_CNT, 1, 32'h0, 1, 32'h0, "R1 count in reset");
    @(negedge clk) rst_n = 1'b1;

    // R2/R3: upper write bits dropped, hold with source 0
    reg_write(A_CFG, 32'hFFFF_FF00);
    advance(3);
    probe(A_CNT, 1, 32'h0, 1, 32'h0, "R3 held count");
    probe(A_CFG, 1, 32'h100, 1, 32'h100, "R2 cfg readback");

    // R4/R9: nanosecond source, wrap on the narrow copy
    reg_write(A_CFG, 32'h0);
    advance(1);
    probe(A_CNT, 1, ns_exp(1, 32), 1, ns_exp(1, 12), "R4 k=1");
    advance(9);
    probe(A_CNT, 1, ns_exp(10, 32), 1, ns_exp(10, 12), "R4 k=10");
    advance(194);
    probe(A_CNT, 1, ns_exp(204, 32), 1, 32'hFF0, "R9 k=204");
    advance(1);
    probe(A_CNT, 1, ns_exp(205, 32), 1, 32'h4, "R9 wrap k=205");

    // R3: hold again zeroes a running count
    reg_write(A_CFG, 32'h100);
    advance(1);
    probe(A_CNT, 1, 32'h0, 1, 32'h0, "R3 hold after run");
    advance(5);
    probe(A_CNT, 1, 32'h0, 1, 32'h0, "R3 hold stays");

    // R5: microsecond source
    reg_write(A_CFG, 32'h001);
    advance(49);
    probe(A_CNT, 1, 32'd0, 1, 32'd0, "R5 k=49");
    advance(1);
    probe(A_CNT, 1, 32'd1, 1, 32'd1, "R5 k=50");
    advance(50);
    probe(A_CNT, 1, 32'd2, 1, 32'd2, "R5 k=100");
    advance(25);
    probe(A_CNT, 1, 32'd2, 1, 32'd2, "R5 k=125");

    // R7: invalid source parks the count
    reg_write(A_CFG, 32'h003);
    advance(1);
    probe(A_CNT, 1, 32'd2, 1, 32'd2, "R7 parked");
    advance(300);
    probe(A_CNT, 1, 32'd2, 1, 32'd2, "R7 parked long");
    probe(A_CFG, 1, 32'h003, 1, 32'h003, "R2 cfg invalid src");

    // R8: source change restarts prescaler, keeps count
    reg_write(A_CFG, 32'h001);
    advance(49);
    probe(A_CNT, 1, 32'd2, 1, 32'd2, "R8 k=49");
    advance(1);
    probe(A_CNT, 1, 32'd3, 1, 32'd3, "R8 k=50");

    // R6: millisecond source from a fresh hold
    reg_write(A_CFG, 32'h102);
    advance(2);
    probe(A_CNT, 1, 32'd0, 1, 32'd0, "R3 hold src2");
    reg_write(A_CFG, 32'h002);
    advance(49999);
    probe(A_CNT, 1, 32'd0, 1, 32'd0, "R6 k=49999");
    advance(1);
    probe(A_CNT, 1, 32'd1, 1, 32'd1, "R6 k=50000");

    // R10: writes elsewhere are ignored, unmapped reads give zero
    reg_write(A_CNT, 32'h0000_0155);
    reg_write(12'h601, 32'hFFFF_FFFF);
    reg_write(12'h7FC, 32'h0000_0100);
    advance(1);
    probe(A_CNT, 1, 32'd1, 1, 32'd1, "R10 count untouched");
    probe(A_CFG, 1, 32'h002, 1, 32'h002, "R10 cfg untouched");
    probe(12'h7FC, 1, 32'h0, 1, 32'h0, "R10 unmapped read");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule